// File: doc/BRIEF.md
# Multi-mode host bus register interface

This block is the slave end of an 8-bit processor bus. It gives an external host read and write access to a small bank of 8-bit registers. A 3-bit personality input sets how two multi-purpose strobe pins are read:

- **Intel-style asynchronous:** separate active-low read and write strobes.
- **Motorola-style asynchronous:** a data strobe plus a read/write direction pin.
- **Clocked synchronous:** an active-low write enable plus the direction pin, both sampled on the bus clock.

In the two asynchronous personalities, chip select and both strobes pass through a two-stage synchronizer before any edge is detected. An Intel write captures address and data into a hold register while the write strobe is seen low. It commits them when the strobe is seen to release. A Motorola access starts on the synchronized falling edge of the data strobe. The data bus is split into an input, an output and an output enable. The output enable is combinational from the raw pins, so the bus is released at once when the strobe goes away. One clock signal serves as both the internal clock and the bus clock. Two single-cycle pulses report completed writes and started reads to the rest of the chip. The data path has no valid/ready handshake: the host's strobes pace every transfer, and the interface never applies back-pressure.

Top module: `hbr_top`

## Requirements
- R1: Personality encoding on `mode_sel`: 3'b000 is Intel-style, 3'b001 is Motorola-style and 3'b100 is synchronous. Any other value writes no register, raises no pulse and never drives the bus.
- R2: While `cs_n` is high, no register is written and `data_oe` stays low in every personality.
- R3: Intel-style read: while `cs_n` and `strb_a` (read strobe) are both low, `data_oe` is high and `data_out` equals the addressed register. `data_oe` falls in the same step that `strb_a` rises, with no clock edge needed.
- R4: Intel-style write: `strb_b` is the active-low write strobe. The address and data present while it is low are written when its release is detected. Each low pulse writes exactly once, however long it lasts.
- R5: Motorola-style read: `strb_a` is an active-low data strobe and `strb_b` is the direction (1 = read, 0 = write). The bus is driven only while `cs_n` is low, `strb_a` is low and `strb_b` is high, and it is released when `strb_a` rises.
- R6: Motorola-style write: a falling data strobe with direction low writes the addressed register exactly once per strobe.
- R7: Synchronous: every rising clock edge that samples `cs_n`, `strb_a` and `strb_b` all low writes `data_in` to the addressed register on that edge. The bus is driven while `cs_n` is low and `strb_b` is high.
- R8: The bank has 12 registers at addresses 0 to 11. Addresses 12 to 15 read as zero, and writes to them change nothing.
- R9: `wr_pulse` is high for exactly one cycle after each register write edge. `rd_pulse` is high for one cycle at the start of each read access; in the asynchronous personalities this comes after synchronization.
- R10: After reset all registers read zero, and `wr_pulse`, `rd_pulse` and `data_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, also the bus clock in synchronous mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Bus personality select |
| cs_n | input | 1 | Active-low chip select |
| strb_a | input | 1 | Read strobe, data strobe or write enable, depending on personality |
| strb_b | input | 1 | Write strobe or read/write direction, depending on personality |
| addr | input | 4 | Register address |
| data_in | input | 8 | Bus value entering the block |
| data_out | output | 8 | Value driven onto the bus |
| data_oe | output | 1 | Bus output enable, high to drive |
| wr_pulse | output | 1 | One-cycle pulse after each register write |
| rd_pulse | output | 1 | One-cycle pulse at the start of each read |

## Verification
In the synchronous personality, a register write and a read of that same register can fall in adjacent bus-clock cycles. As a result, the write pulse and the bus drive of the fresh value coincide in the cycle right after the write edge. The bench provokes this by keeping chip select low and turning the direction pin to read on the very next edge after a single-edge write. In that cycle it expects `wr_pulse` high, `data_oe` high and the newly written byte on `data_out`. The scoreboard then checks the read pulse that follows against the same value.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  localparam logic [2:0] MODE_INTEL = 3'b000;
  localparam logic [2:0] MODE_MOTO  = 3'b001;
  localparam logic [2:0] MODE_SYNC  = 3'b100;

  function automatic logic mode_legal(input logic [2:0] m);
    return (m == MODE_INTEL) || (m == MODE_MOTO) || (m == MODE_SYNC);
  endfunction
endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
  parameter int          W      = 3,
  parameter logic [W-1:0] IDLE  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= IDLE;
      q      <= IDLE;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/hbr_decode.sv
module hbr_decode
  import hbr_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic          cs_n,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic          sy_cs_n,
  input  logic          sy_a,
  input  logic          sy_b,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_start,
  output logic          drive_en
);
  logic          intel_wa;
  logic          prev_wa;
  logic          act_lvl;
  logic          prev_act;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  assign intel_wa = ~sy_cs_n & ~sy_b;

  always_comb begin
    act_lvl  = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = addr;
    wr_data  = din;
    rd_start = 1'b0;
    drive_en = 1'b0;
    case (mode_sel)
      MODE_INTEL: begin
        act_lvl  = ~sy_cs_n & ~sy_a;
        rd_start = act_lvl & ~prev_act;
        wr_en    = prev_wa & ~intel_wa;
        wr_addr  = hold_addr;
        wr_data  = hold_data;
        drive_en = ~cs_n & ~strb_a;
      end
      MODE_MOTO: begin
        act_lvl  = ~sy_cs_n & ~sy_a;
        wr_en    = act_lvl & ~prev_act & ~sy_b;
        rd_start = act_lvl & ~prev_act & sy_b;
        drive_en = ~cs_n & ~strb_a & strb_b;
      end
      MODE_SYNC: begin
        act_lvl  = ~cs_n & strb_b;
        rd_start = act_lvl & ~prev_act;
        wr_en    = ~cs_n & ~strb_a & ~strb_b;
        drive_en = ~cs_n & strb_b;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wa   <= 1'b0;
      prev_act  <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      prev_wa  <= intel_wa;
      prev_act <= act_lvl;
      if (mode_sel == MODE_INTEL && intel_wa) begin
        hold_addr <= addr;
        hold_data <= din;
      end
    end
  end

  // R4/R6: asynchronous personalities never issue back-to-back write commits
  p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_sel != MODE_SYNC) |=> !wr_en);

  // R1: the bus is only driven under a legal personality
  p_drive_legal_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> mode_legal(mode_sel));

  // R1: no write commit under an illegal personality
  p_no_write_bad_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mode_legal(mode_sel));
endmodule

// File: rtl/hbr_regfile.sv
module hbr_regfile #(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int NUM_REGS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int SPAN = 1 << AW;
  localparam int LAST = (NUM_REGS < SPAN) ? NUM_REGS : SPAN;

  logic [LAST-1:0][DW-1:0] regs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < LAST; i++) begin
        if (wr_addr == AW'(i)) regs[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < LAST; i++) begin
      if (rd_addr == AW'(i)) rd_data = regs[i];
    end
  end

  // R8: contents only move on a write
  p_hold_without_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));

  // R8: writes beyond the bank leave it untouched
  p_unimpl_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && 32'(wr_addr) >= LAST) |=> $stable(regs));
endmodule

// File: rtl/hbr_top.sv
module hbr_top
  import hbr_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int NUM_REGS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_sel,
  input  logic          cs_n,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          wr_pulse,
  output logic          rd_pulse
);
  logic [2:0]    sy;
  logic          wr_en;
  logic          rd_start;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  hbr_sync #(.W(3), .IDLE(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, strb_a, strb_b}),
    .q     (sy)
  );

  hbr_decode #(.AW(AW), .DW(DW)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .cs_n     (cs_n),
    .strb_a   (strb_a),
    .strb_b   (strb_b),
    .sy_cs_n  (sy[2]),
    .sy_a     (sy[1]),
    .sy_b     (sy[0]),
    .addr     (addr),
    .din      (data_in),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_start (rd_start),
    .drive_en (data_oe)
  );

  hbr_regfile #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (addr),
    .rd_data (data_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      rd_pulse <= 1'b0;
    end else begin
      wr_pulse <= wr_en;
      rd_pulse <= rd_start;
    end
  end

  // R2: a deselected device never drives the bus
  p_release_when_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !data_oe);

  // R9: a write pulse is always preceded by a selected cycle in the previous cycle
  p_pulse_after_select_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pulse && $past(mode_sel) == MODE_SYNC) |-> !$past(cs_n));
endmodule

// File: tb/hbr_top_bench.sv
module hbr_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       cs_n = 1'b1, strb_a = 1'b1, strb_b = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic       data_oe, wr_pulse, rd_pulse;

  int nchk = 0, nfail = 0, wr_cnt = 0, rd_cnt = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  hbr_top u_hbr_top (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n),
    .strb_a(strb_a), .strb_b(strb_b), .addr(addr), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  // monitor: pulse counting and read scoreboard
  always @(negedge clk) begin
    if (wr_pulse) wr_cnt++;
    if (rd_pulse) begin
      rd_cnt++;
      if (exp_q.size() == 0) check(0, "R9 unexpected read pulse", 1, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check(data_oe && data_out == e, "R9 scoreboard read", {data_oe, data_out}, {1'b1, e});
      end
    end
  end

  task automatic idle(input int n);
    cs_n = 1; strb_a = 1; strb_b = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic intel_write(input logic [3:0] a, input logic [7:0] d, input int hold);
    @(negedge clk); mode_sel = 3'b000; addr = a; data_in = d; cs_n = 0;
    @(negedge clk); strb_b = 0;
    repeat (hold) @(negedge clk);
    strb_b = 1;
    repeat (4) @(negedge clk);
    idle(3);
  endtask

  task automatic intel_read(input logic [3:0] a, input logic [7:0] e, input string req);
    @(negedge clk); mode_sel = 3'b000; addr = a; cs_n = 0; strb_a = 0;
    exp_q.push_back(e);
    repeat (5) @(negedge clk);
    check(data_oe && data_out == e, req, {data_oe, data_out}, {1'b1, e});
    strb_a = 1; #1;
    check(!data_oe, "R3 release on strobe rise", data_oe, 0);
    @(negedge clk); idle(3);
  endtask

  task automatic moto_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); mode_sel = 3'b001; addr = a; data_in = d; cs_n = 0; strb_b = 0;
    @(negedge clk); strb_a = 0;
    repeat (8) @(negedge clk);
    strb_a = 1;
    repeat (4) @(negedge clk);
    idle(3);
  endtask

  task automatic moto_read(input logic [3:0] a, input logic [7:0] e);
    @(negedge clk); mode_sel = 3'b001; addr = a; cs_n = 0; strb_b = 1;
    @(negedge clk); #1;
    check(!data_oe, "R5 no drive before data strobe", data_oe, 0);
    strb_a = 0; exp_q.push_back(e);
    repeat (5) @(negedge clk);
    check(data_oe && data_out == e, "R5 motorola read", {data_oe, data_out}, {1'b1, e});
    strb_a = 1; #1;
    check(!data_oe, "R5 release on strobe rise", data_oe, 0);
    @(negedge clk); idle(3);
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check(!data_oe && !wr_pulse && !rd_pulse, "R10 reset outputs", {data_oe, wr_pulse, rd_pulse}, 0);
    intel_read(4'd5, 8'h00, "R10 register zero after reset");

    // R4 Intel write, short and long strobe, one pulse each
    w0 = wr_cnt;
    intel_write(4'd2, 8'hA5, 3);
    check(wr_cnt - w0 == 1, "R4 one write per strobe", wr_cnt - w0, 1);
    w0 = wr_cnt;
    intel_write(4'd7, 8'h3C, 25);
    check(wr_cnt - w0 == 1, "R4 long strobe one write", wr_cnt - w0, 1);
    intel_read(4'd2, 8'hA5, "R3 intel read reg2");
    intel_read(4'd7, 8'h3C, "R3 intel read reg7");

    // R2 deselected strobes
    w0 = wr_cnt;
    @(negedge clk); mode_sel = 3'b000; addr = 4'd2; data_in = 8'hFF; cs_n = 1; strb_b = 0; strb_a = 0;
    repeat (4) @(negedge clk); #1;
    check(!data_oe, "R2 no drive when deselected", data_oe, 0);
    strb_b = 1; strb_a = 1;
    repeat (5) @(negedge clk);
    check(wr_cnt == w0, "R2 no write when deselected", wr_cnt - w0, 0);
    intel_read(4'd2, 8'hA5, "R2 register unchanged");

    // R6 / R5 Motorola
    w0 = wr_cnt;
    moto_write(4'd9, 8'h5A);
    check(wr_cnt - w0 == 1, "R6 one write per data strobe", wr_cnt - w0, 1);
    moto_read(4'd9, 8'h5A);

    // R8 unimplemented address
    intel_write(4'd13, 8'h77, 3);
    intel_read(4'd13, 8'h00, "R8 unimplemented reads zero");
    intel_read(4'd2, 8'hA5, "R8 bank untouched");

    // R7 synchronous: write then read on the next edge
    w0 = wr_cnt;
    @(negedge clk); mode_sel = 3'b100; addr = 4'd3; data_in = 8'hC3; cs_n = 0; strb_a = 0; strb_b = 0;
    @(negedge clk); strb_a = 1; strb_b = 1; exp_q.push_back(8'hC3); #1;
    check(wr_pulse && data_oe && data_out == 8'hC3, "R7 write and read adjacent", {wr_pulse, data_oe, data_out}, {2'b11, 8'hC3});
    repeat (3) @(negedge clk);
    idle(2);
    check(wr_cnt - w0 == 1, "R9 single sync write pulse", wr_cnt - w0, 1);

    // R7 multi-edge sync write: one write per edge
    w0 = wr_cnt;
    @(negedge clk); addr = 4'd4; data_in = 8'h11; cs_n = 0; strb_a = 0; strb_b = 0;
    @(negedge clk); data_in = 8'h22;
    @(negedge clk); data_in = 8'h33;
    @(negedge clk); idle(3);
    check(wr_cnt - w0 == 3, "R7 write on each edge", wr_cnt - w0, 3);
    intel_read(4'd4, 8'h33, "R7 last edge wins");

    // R1 illegal personality
    w0 = wr_cnt;
    @(negedge clk); mode_sel = 3'b010; addr = 4'd4; data_in = 8'hEE; cs_n = 0; strb_a = 0; strb_b = 0;
    repeat (5) @(negedge clk); #1;
    check(!data_oe, "R1 no drive in illegal mode", data_oe, 0);
    idle(6);
    check(wr_cnt == w0, "R1 no write in illegal mode", wr_cnt - w0, 0);
    intel_read(4'd4, 8'h33, "R1 register unchanged");

    check(exp_q.size() == 0, "R9 every read pulsed", exp_q.size(), 0);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      report();
      $finish;
    end
  end
endmodule